// File: doc/BRIEF.md
# Round-Robin Thread Issue Scheduler

This block decides, on every clock, which hardware thread of a barrel-style core may send an instruction into a pipeline of fixed depth. Each thread has three inputs. An in-use flag says the thread exists. A pause request, tagged with the thread's number, stops it while it waits on synchronisation or I/O. A dedicated wake line lets the resource that was holding the thread release it again. Threads that are both in use and not paused are runnable. The scheduler grants them in a rotating order and skips every thread that is not runnable.

A per-thread cooldown counter makes sure a thread cannot issue again until its previous instruction has left the pipeline. When fewer threads are runnable than the pipeline is deep, some issue slots therefore stay empty. A thread released by its wake line takes part in the rotation again. Its first grant afterwards is flagged as a re-issue, so the core replays the instruction that stalled instead of moving past it. When nothing is runnable, an idle output goes high and can be used to stop the core clock.

Top module: `rrIssueSched`

## Requirements
- R1: A thread whose in-use flag is low, or which is paused, is never granted an issue slot.
- R2: Grants rotate in ascending thread-number order, wrapping from the highest thread to thread 0. The search for the next grant starts at the thread after the one granted last.
- R3: After a thread issues, at least PIPE_DEPTH cycles pass before it issues again. Slots with no eligible thread drive issueValid low.
- R4: With n runnable threads, each one issues in every window of max(n, PIPE_DEPTH) cycles. From reset, runnable thread j in ascending order (j counted from 0) issues in the cycles c where c mod max(n, PIPE_DEPTH) = j.
- R5: A pause request (pauseValid high with pauseTid = t) pauses thread t from the next cycle onward, until its wake line is asserted.
- R6: Asserting readyReq[t] while thread t is paused unpauses it from the next cycle. The first grant of t after that has reissue high, and later grants of t have reissue low.
- R7: If pauseValid with pauseTid = t and readyReq[t] are high in the same cycle, the thread does not become paused and it keeps issuing.
- R8: A woken thread issues within max(n, PIPE_DEPTH) cycles of the cycle in which its pause is cleared.
- R9: idle is high exactly when no thread is both in use and unpaused, and issueValid is low whenever idle is high.
- R10: After reset, no thread is paused, all cooldowns are clear, and the rotation starts at thread 0. With every thread in use, thread 0 issues in the first cycle.
- R11: Moving from one thread to another costs no cycle. With at least PIPE_DEPTH runnable threads, issueValid is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| threadInUse | input | NUM_THREADS | Per-thread in-use flag |
| pauseValid | input | 1 | Pause request strobe |
| pauseTid | input | $clog2(NUM_THREADS) | Thread targeted by the pause request |
| readyReq | input | NUM_THREADS | Per-thread wake line from resources |
| issueValid | output | 1 | An instruction issues this cycle |
| issueTid | output | $clog2(NUM_THREADS) | Thread granted this cycle |
| reissue | output | 1 | The granted thread is replaying the instruction that paused it |
| idle | output | 1 | No runnable thread; clock may be gated |

## Verification
The assertions are checked on every cycle. They cover the following: every grant goes to a thread that is in use, unpaused and out of cooldown, and that thread is not eligible in the following cycle. A wake line beats a pause request that arrives with it. A pause request with no wake line sets the pause, and a wake on a paused thread sets the re-issue flag. idle and issueValid are never both high, and reissue is high only together with a grant. Other properties span many cycles and can only be shown by the bench's scenarios: the exact rotation order and the slot pattern for every in-use mask, the empty slots when fewer threads than the pipeline depth are runnable, the bound on wake-up latency, and re-issue being flagged only on the first grant after a wake.

// File: rtl/rrSchedPkg.sv
package rrSchedPkg;

  typedef struct packed {
    logic fire;     // a thread was granted this cycle
    logic reissue;  // granted thread is replaying its stalled instruction
  } issueFlags_t;

  function automatic int wrapIdx(input int base, input int step, input int modulus);
    int s;
    s = base + step;
    if (s >= modulus) s = s - modulus;
    return s;
  endfunction

endpackage

// File: rtl/rrSchedState.sv
module rrSchedState #(
  parameter int NUM_THREADS = 8,
  parameter int PIPE_DEPTH  = 4,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int CW = $clog2(PIPE_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] inUse,
  input  logic                   pauseValid,
  input  logic [TW-1:0]          pauseTid,
  input  logic [NUM_THREADS-1:0] readyReq,
  input  logic [NUM_THREADS-1:0] grantOh,
  output logic [NUM_THREADS-1:0] eligible,
  output logic [NUM_THREADS-1:0] runnable,
  output logic [NUM_THREADS-1:0] wakeFlag
);

  localparam logic [CW-1:0] COOL_LOAD = CW'(PIPE_DEPTH - 1);

  for (genvar i = 0; i < NUM_THREADS; i++) begin : gThread
    logic [CW-1:0] coolCnt;
    logic          paused;
    logic          wakePend;
    logic          pauseHit;

    assign pauseHit = pauseValid && (pauseTid == TW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coolCnt  <= '0;
        paused   <= 1'b0;
        wakePend <= 1'b0;
      end else begin
        if (grantOh[i])         coolCnt <= COOL_LOAD;
        else if (coolCnt != '0) coolCnt <= coolCnt - 1'b1;

        if (grantOh[i]) wakePend <= 1'b0;

        if (readyReq[i]) begin
          paused <= 1'b0;
          if (paused) wakePend <= 1'b1;
        end else if (pauseHit) begin
          paused <= 1'b1;
        end
      end
    end

    assign runnable[i] = inUse[i] && !paused;
    assign eligible[i] = runnable[i] && (coolCnt == '0);
    assign wakeFlag[i] = wakePend;

    // R1: grant only to an in-use, unpaused, cooled-down thread
    a_r1_grant_runnable: assert property (@(posedge clk) disable iff (!rstN)
      grantOh[i] |-> (inUse[i] && !paused && coolCnt == '0));

    // R3: a granted thread is not eligible in the following cycle
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
      grantOh[i] |=> !eligible[i]);

    // R7: a wake line beats a pause request arriving with it
    a_r7_ready_wins: assert property (@(posedge clk) disable iff (!rstN)
      readyReq[i] |=> !paused);

    // R5: a pause request alone takes effect on the next cycle
    a_r5_pause_sets: assert property (@(posedge clk) disable iff (!rstN)
      (pauseHit && !readyReq[i]) |=> paused);

    // R6: waking a paused thread marks its next grant as a replay
    a_r6_wake_marks: assert property (@(posedge clk) disable iff (!rstN)
      (paused && readyReq[i]) |=> wakePend);
  end

endmodule

// File: rtl/rrSchedPick.sv
module rrSchedPick
  import rrSchedPkg::*;
#(
  parameter int NUM_THREADS = 8,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] eligible,
  input  logic [NUM_THREADS-1:0] wakeFlag,
  output logic [NUM_THREADS-1:0] grantOh,
  output logic [TW-1:0]          grantTid,
  output issueFlags_t            flags
);

  logic [TW-1:0] rrPtr;
  logic          found;

  always_comb begin
    grantOh  = '0;
    grantTid = '0;
    found    = 1'b0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      int idx;
      idx = wrapIdx(int'(rrPtr), k, NUM_THREADS);
      if (!found && eligible[idx]) begin
        found        = 1'b1;
        grantOh[idx] = 1'b1;
        grantTid     = TW'(idx);
      end
    end
  end

  assign flags.fire    = found;
  assign flags.reissue = |(grantOh & wakeFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (found) begin
      rrPtr <= (int'(grantTid) == NUM_THREADS - 1) ? '0 : grantTid + 1'b1;
    end
  end

  // R1: a fired grant lands on a thread the state tracker reports eligible
  a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rstN)
    flags.fire |-> ((grantOh & eligible) != '0));

  // R11: an eligible thread is never left waiting on an empty slot
  a_r11_no_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
    (eligible != '0) |-> flags.fire);

endmodule

// File: rtl/rrIssueSched.sv
module rrIssueSched
  import rrSchedPkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int PIPE_DEPTH  = 4,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_THREADS-1:0] threadInUse,
  input  logic                   pauseValid,
  input  logic [TW-1:0]          pauseTid,
  input  logic [NUM_THREADS-1:0] readyReq,
  output logic                   issueValid,
  output logic [TW-1:0]          issueTid,
  output logic                   reissue,
  output logic                   idle
);

  logic [NUM_THREADS-1:0] eligible;
  logic [NUM_THREADS-1:0] runnable;
  logic [NUM_THREADS-1:0] wakeFlag;
  logic [NUM_THREADS-1:0] grantOh;
  issueFlags_t            flags;

  rrSchedState #(.NUM_THREADS(NUM_THREADS), .PIPE_DEPTH(PIPE_DEPTH)) uState (
    .clk        (clk),
    .rstN       (rstN),
    .inUse      (threadInUse),
    .pauseValid (pauseValid),
    .pauseTid   (pauseTid),
    .readyReq   (readyReq),
    .grantOh    (grantOh),
    .eligible   (eligible),
    .runnable   (runnable),
    .wakeFlag   (wakeFlag)
  );

  rrSchedPick #(.NUM_THREADS(NUM_THREADS)) uPick (
    .clk      (clk),
    .rstN     (rstN),
    .eligible (eligible),
    .wakeFlag (wakeFlag),
    .grantOh  (grantOh),
    .grantTid (issueTid),
    .flags    (flags)
  );

  assign issueValid = flags.fire;
  assign reissue    = flags.reissue;
  assign idle       = ~|runnable;

  // R9: nothing issues while the block reports idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !issueValid);

  // R6: the replay flag only accompanies a real grant
  a_r6_reissue_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    reissue |-> issueValid);

endmodule

// File: tb/tb_rrIssueSched.sv
module tb_rrIssueSched;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int PD = 4;
  localparam int TW = $clog2(NT);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] threadInUse = '0;
  logic          pauseValid = 1'b0;
  logic [TW-1:0] pauseTid = '0;
  logic [NT-1:0] readyReq = '0;
  logic          issueValid;
  logic [TW-1:0] issueTid;
  logic          reissue;
  logic          idle;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrIssueSched #(.NUM_THREADS(NT), .PIPE_DEPTH(PD)) dut (
    .clk(clk), .rstN(rstN), .threadInUse(threadInUse), .pauseValid(pauseValid),
    .pauseTid(pauseTid), .readyReq(readyReq), .issueValid(issueValid),
    .issueTid(issueTid), .reissue(reissue), .idle(idle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reset with a mask; returns at negedge+1 of cycle 0
  task automatic doReset(input logic [NT-1:0] mask);
    rstN = 1'b0;
    threadInUse = mask;
    pauseValid = 1'b0;
    readyReq = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // one-cycle pulse, set after a posedge, captured by the next posedge
  task automatic pulse(input logic pv, input int ptid, input logic [NT-1:0] rdy);
    @(posedge clk); #1;
    pauseValid = pv;
    pauseTid = TW'(ptid);
    readyReq = rdy;
    @(posedge clk); #1;
    pauseValid = 1'b0;
    readyReq = '0;
  endtask

  // wait from now for a grant of tid within maxCyc cycles; returns cycle number (0 = none)
  task automatic waitGrant(input int tid, input int maxCyc, output int at, output logic rei);
    at = 0;
    rei = 1'b0;
    for (int k = 1; k <= maxCyc; k++) begin
      @(negedge clk);
      if (at == 0 && issueValid && int'(issueTid) == tid) begin
        at = k;
        rei = reissue;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int at;
    logic rei;
    bit sawThree;
    bit sawFive;

    // R10: reset state with every thread in use
    doReset('1);
    check(issueValid && issueTid == 0 && !reissue && !idle, "R10 first grant",
          {27'(0), issueValid, issueTid}, 8);

    // R1 R2 R3 R4 R9 R11: sweep every in-use mask from reset
    for (int mask = 0; mask < (1 << NT); mask++) begin
      int setArr[NT];
      int n;
      int per;
      n = 0;
      for (int t = 0; t < NT; t++) if (mask[t]) begin setArr[n] = t; n++; end
      per = (n > PD) ? n : PD;
      doReset(NT'(mask));
      check(idle == (n == 0), "R9 idle", int'(idle), int'(n == 0));
      for (int c = 0; c < 20; c++) begin
        int r;
        bit expV;
        int expT;
        bit ok;
        if (c > 0) @(negedge clk);
        r = c % per;
        expV = (r < n);
        expT = expV ? setArr[r] : 0;
        ok = (issueValid == expV) && (!expV || int'(issueTid) == expT) && !reissue;
        check(ok, "R1 R2 R3 R4 R11 slot", int'(issueValid) * 16 + int'(issueTid),
              int'(expV) * 16 + expT);
      end
    end

    // R5 R6 R8: pause thread 3 with all threads in use, then wake it
    doReset('1);
    repeat (5) @(posedge clk);
    pulse(1'b1, 3, '0);
    sawThree = 1'b0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (issueValid && issueTid == 3) sawThree = 1'b1;
    end
    check(!sawThree, "R5 paused thread silent", int'(sawThree), 0);
    check(!idle, "R9 not idle with runnable", int'(idle), 0);
    @(posedge clk); #1;
    readyReq = NT'(1 << 3);
    @(posedge clk); #1;
    readyReq = '0;
    // the posedge just passed cleared the pause; this cycle is k=1
    at = 0; rei = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (k > 1) @(negedge clk); else #(CLK_PERIOD/2 - 1);
      if (at == 0 && issueValid && issueTid == 3) begin at = k; rei = reissue; end
    end
    check(at >= 1 && at <= NT, "R8 wake latency 8 threads", at, NT);
    check(rei == 1'b1, "R6 first grant after wake is replay", int'(rei), 1);
    waitGrant(3, 12, at, rei);
    check(at != 0 && rei == 1'b0, "R6 later grant not replay", int'(rei) + 2 * int'(at == 0), 0);

    // R7: pause and wake for thread 5 in the same cycle
    pulse(1'b1, 5, NT'(1 << 5));
    sawFive = 1'b0;
    for (int k = 0; k < 2 * NT; k++) begin
      @(negedge clk);
      if (issueValid && issueTid == 5) begin
        sawFive = 1'b1;
        check(!reissue, "R7 no replay when pause lost", int'(reissue), 0);
      end
    end
    check(sawFive, "R7 thread keeps issuing", int'(sawFive), 1);

    // R8 R3: two runnable threads, wake latency bounded by pipeline depth
    doReset(NT'(8'b0100_0010));
    repeat (3) @(posedge clk);
    pulse(1'b1, 6, '0);
    sawThree = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (issueValid && issueTid == 6) sawThree = 1'b1;
    end
    check(!sawThree, "R5 paused thread 6 silent", int'(sawThree), 0);
    @(posedge clk); #1;
    readyReq = NT'(1 << 6);
    @(posedge clk); #1;
    readyReq = '0;
    at = 0; rei = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (k > 1) @(negedge clk); else #(CLK_PERIOD/2 - 1);
      if (at == 0 && issueValid && issueTid == 6) begin at = k; rei = reissue; end
    end
    check(at >= 1 && at <= PD, "R8 wake latency 2 threads", at, PD);
    check(rei == 1'b1, "R6 replay with 2 threads", int'(rei), 1);

    // R9: all threads paused makes the block idle
    doReset(NT'(8'b0000_0001));
    pulse(1'b1, 0, '0);
    @(negedge clk);
    check(idle && !issueValid, "R9 idle when all paused", int'(idle) * 2 + int'(issueValid), 2);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule